// File: doc/BRIEF.md
# Microcoded Byte-Wide Processor Core

This block is a small 8-bit processor that fetches and runs a program held in a 32-byte read-only store, working on a 256-byte data RAM. Eight 8-bit registers form the register file, and register 7 doubles as the program counter. Every instruction is 16 bits long. It is pulled in one byte at a time through a single internal byte port and then executed, under a repeating five-step control sequence. The data path has one adder and nothing else. Loads, stores, immediate adds and register adds all pass through the adder or the memory port. Branches are immediate adds whose destination is register 7, and "load immediate" is an immediate add from a register that still holds zero.

The program image is a parameter, so an integrator fixes the program when the core is instantiated. Each store that the core executes is also presented on an outbound valid/ready stream that carries the address and the data. While the core has a store pending, `st_valid` is high. The store commits to RAM, and the core moves on, only in a cycle where `st_ready` is high. While `st_ready` is low, the core holds the store in its execute step with address and data unchanged, so a slow consumer throttles the processor. The program counter and the control step are brought out as plain status pins.

Top module: `cpu8_core`

## Requirements
- R1: While synchronous active-high `rst` is asserted, the following are cleared at the clock edge: the step counter, all eight registers (including the program counter), both instruction byte registers and every RAM byte. After release, the core fetches first from address 0.
- R2: `step` runs 0,1,2,3,4 and then returns to 0. Step 4 is the execute step and is the only step that can be held, by a stalled store.
- R3: Step 0 latches the byte at the address held by PC as the immediate byte. Step 1 adds 1 to PC. Step 2 latches the byte at the new PC as the control byte. Step 3 adds 1 to PC again. During execute, PC therefore equals the instruction address plus 2.
- R4: Control byte fields: bits [7:6] are the operation (00 load, 01 store, 10 immediate add, 11 register add), bits [5:3] are rd and bits [2:0] are rs. The immediate byte is stored at the even address and the control byte at the odd address that follows it.
- R5: Immediate add writes rs + imm, modulo 256, into rd, with imm taken as two's complement. With rd = 7 this acts as a relative branch, and imm = 0xF8 jumps back by 8 bytes.
- R6: Register add writes rd + rs, modulo 256, into rd. No flags exist.
- R7: Load copies the byte at the address held by rs into rd. Addresses 0 to 31 read the program store. All higher addresses read the RAM.
- R8: Store writes rd to the address held by rs. A store to an address below 32 leaves every memory byte unchanged.
- R9: During the execute step of a store, `st_valid` is high and `st_addr`/`st_data` show the address held by rs and the value of rd. `st_valid` is low in every other step. While `st_ready` is low, `st_valid`, `st_addr` and `st_data` hold and the step does not advance.
- R10: With the default program, the core repeatedly loads RAM byte 0x80, adds 1 and stores the result back. The k-th store event carries address 0x80 and data k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | output | 1 | A store is being executed |
| st_ready | input | 1 | Consumer accepts the store; low stalls the core |
| st_addr | output | 8 | Store address |
| st_data | output | 8 | Store data |
| pc | output | 8 | Current program counter (register 7) |
| step | output | 3 | Current control step, 0 to 4 |

## Verification
The assertions assume that `st_ready` has a defined level at every rising edge and that `rst` is held for at least one edge at start-up. The stall and wrap properties also assume that the step counter only leaves step 4 on an accepted store or a non-store instruction. The bench changes `st_ready` only on falling edges, in a fixed pattern of one low cycle in three. A second instance, whose ready is tied high, runs a program that exercises wrap-around, loads from the program store and an ignored store to the program store. Both programs keep every jump inside the programmed area, so no undefined opcode path is reached.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DW        = 8;
  localparam int NREG      = 8;
  localparam int NSTEP     = 5;
  localparam int STEPW     = $clog2(NSTEP);
  localparam int ROM_BYTES = 32;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADDI  = 2'b10,
    OP_ADDR  = 2'b11
  } op_e;

  typedef enum logic [STEPW-1:0] {
    ST_FETCH_IMM = 3'd0,
    ST_BUMP1     = 3'd1,
    ST_FETCH_CTL = 3'd2,
    ST_BUMP2     = 3'd3,
    ST_EXEC      = 3'd4
  } step_e;
endpackage

// File: rtl/cpu8_stepper.sv
module cpu8_stepper
  import cpu8_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output step_e step
);
  always_ff @(posedge clk) begin
    if (rst)
      step <= ST_FETCH_IMM;
    else if (adv)
      step <= (step == ST_EXEC) ? ST_FETCH_IMM : step_e'(step + 1'b1);
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int W = 8,
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [$clog2(N)-1:0] ra_a,
  input  logic [$clog2(N)-1:0] ra_b,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic                 pc_inc,
  output logic [W-1:0]         pc
);
  localparam int PCI = N - 1;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else begin
      if (pc_inc) regs[PCI] <= regs[PCI] + 1'b1;
      if (we)     regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign pc   = regs[PCI];
endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
  parameter int                    W         = 8,
  parameter int                    ROM_BYTES = 32,
  parameter logic [ROM_BYTES*W-1:0] ROM_IMAGE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata
);
  localparam int RAM_DEPTH = 1 << W;
  localparam int RA        = $clog2(ROM_BYTES);

  logic [W-1:0] rom [ROM_BYTES];
  logic [W-1:0] ram [RAM_DEPTH];

  for (genvar g = 0; g < ROM_BYTES; g++) begin : g_rom
    assign rom[g] = ROM_IMAGE[g*W +: W];
  end

  logic rd_rom, wr_ram;
  assign rd_rom = (raddr < W'(ROM_BYTES));
  assign wr_ram = we && (waddr >= W'(ROM_BYTES));
  assign rdata  = rd_rom ? rom[raddr[RA-1:0]] : ram[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (wr_ram) begin
      ram[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/cpu8_adder.sv
module cpu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter logic [ROM_BYTES*DW-1:0] ROM_IMAGE =
    {{22{8'h00}}, 80'hBF_F8_41_00_80_01_01_00_88_80}
) (
  input  logic          clk,
  input  logic          rst,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [DW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic [DW-1:0] pc,
  output logic [2:0]    step
);
  localparam int RW = $clog2(NREG);

  step_e             cur_step;
  logic [DW-1:0]     imm_q, ctl_q;
  op_e               op;
  logic [RW-1:0]     rd_idx, rs_idx;
  logic [DW-1:0]     rd_val, rs_val, mem_q, mem_a, sum, add_a, add_b, wb_data;
  logic              in_exec, adv, wb_en, bump;

  assign op     = op_e'(ctl_q[7:6]);
  assign rd_idx = ctl_q[5:3];
  assign rs_idx = ctl_q[2:0];

  assign in_exec  = (cur_step == ST_EXEC);
  assign st_valid = in_exec && (op == OP_STORE);
  assign st_addr  = rs_val;
  assign st_data  = rd_val;
  assign adv      = !(st_valid && !st_ready);
  assign bump     = (cur_step == ST_BUMP1) || (cur_step == ST_BUMP2);

  assign mem_a   = in_exec ? rs_val : pc;
  assign add_a   = (op == OP_ADDR) ? rd_val : rs_val;
  assign add_b   = (op == OP_ADDR) ? rs_val : imm_q;
  assign wb_en   = in_exec && (op != OP_STORE);
  assign wb_data = (op == OP_LOAD) ? mem_q : sum;
  assign step    = cur_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      imm_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cur_step == ST_FETCH_IMM) imm_q <= mem_q;
      if (cur_step == ST_FETCH_CTL) ctl_q <= mem_q;
    end
  end

  cpu8_stepper u_seq (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .step(cur_step)
  );

  cpu8_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .ra_a  (rd_idx),
    .ra_b  (rs_idx),
    .rd_a  (rd_val),
    .rd_b  (rs_val),
    .we    (wb_en),
    .waddr (rd_idx),
    .wdata (wb_data),
    .pc_inc(bump),
    .pc    (pc)
  );

  cpu8_adder #(.W(DW)) u_add (
    .a  (add_a),
    .b  (add_b),
    .sum(sum)
  );

  cpu8_mem #(.W(DW), .ROM_BYTES(ROM_BYTES), .ROM_IMAGE(ROM_IMAGE)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .raddr(mem_a),
    .rdata(mem_q),
    .we   (st_valid && st_ready),
    .waddr(rs_val),
    .wdata(rd_val)
  );
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       st_valid,
  input logic       st_ready,
  input logic [7:0] st_addr,
  input logic [7:0] st_data,
  input logic [7:0] pc,
  input logic [2:0] step
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (step == 3'd0 && pc == 8'd0));

  a_r2_step_legal: assert property (@(posedge clk) disable iff (rst)
    step <= 3'd4);

  a_r2_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd4 && !(st_valid && !st_ready)) |=> step == 3'd0);

  a_r3_pc_bump: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd1 || step == 3'd3) |=> pc == $past(pc) + 8'd1);

  a_r9_valid_only_exec: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> step == 3'd4);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=>
      (st_valid && $stable(st_addr) && $stable(st_data) && step == 3'd4));
endmodule

bind cpu8_core cpu8_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .st_valid(st_valid),
  .st_ready(st_ready),
  .st_addr (st_addr),
  .st_data (st_data),
  .pc      (pc),
  .step    (step)
);

// File: tb/tb_cpu8_core.sv
`timescale 1ns/1ps
module tb_cpu8_core;
  localparam logic [255:0] PROG_B =
    {{8{8'h00}}, 192'hBF_FE_6B_00_AD_01_2B_00_63_00_21_00_59_00_53_00_98_90_D1_00_90_FF_88_05};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic rdy_a = 1'b1;
  logic va, vb;
  logic [7:0] aa, da, pa, ab, db, pb;
  logic [2:0] sa, sb;

  cpu8_core dut (
    .clk(clk), .rst(rst), .st_valid(va), .st_ready(rdy_a),
    .st_addr(aa), .st_data(da), .pc(pa), .step(sa)
  );

  cpu8_core #(.ROM_IMAGE(PROG_B)) dut_b (
    .clk(clk), .rst(rst), .st_valid(vb), .st_ready(1'b1),
    .st_addr(ab), .st_data(db), .pc(pb), .step(sb)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    string      tag;
  } ev_t;

  ev_t q_a[$];
  ev_t q_b[$];
  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(bit which, logic [7:0] a, logic [7:0] d, string tag);
    ev_t e;
    e.a = a; e.d = d; e.tag = tag;
    if (which) q_b.push_back(e);
    else       q_a.push_back(e);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit         prev_stall = 0;
    logic [7:0] p_a = '0, p_d = '0;
    int         a_seen = 0;
    ev_t        e;

    for (int k = 1; k <= 60; k++) push_exp(0, 8'h80, 8'(k), "R10");
    push_exp(1, 8'h90, 8'h04, "R6/R4 wrap add");
    push_exp(1, 8'h05, 8'h90, "R9 store to ROM range presented");
    push_exp(1, 8'h90, 8'hD1, "R8/R7 ROM byte unchanged");
    push_exp(1, 8'h90, 8'hD2, "R7/R5 RAM readback");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pa == 8'd0 && pb == 8'd0, "R1", "pc in reset", pa, 0);
    check(sa == 3'd0 && sb == 3'd0, "R1", "step in reset", sa, 0);
    check(!va && !vb, "R1", "no store in reset", va, 0);
    rst = 1'b0;

    for (int cyc = 1; cyc <= 480; cyc++) begin
      @(negedge clk);
      if (cyc <= 10) check(sb == 3'(cyc % 5), "R2", "step sequence", sb, cyc % 5);
      if (cyc == 2)  check(pb == 8'd1, "R3", "pc after first bump", pb, 1);
      if (cyc == 4)  check(pb == 8'd2, "R3", "pc at first execute", pb, 2);
      if (cyc == 9)  check(pb == 8'd4, "R3", "pc at second execute", pb, 4);
      if (cyc <= 3)  check(!vb, "R9", "valid outside execute", vb, 0);

      if (prev_stall) begin
        check(va && aa == p_a && da == p_d && sa == 3'd4, "R9",
              "hold under back-pressure", {va, aa, da}, {1'b1, p_a, p_d});
      end

      rdy_a = (cyc % 3) != 0;

      if (va && rdy_a) begin
        if (q_a.size() == 0) begin
          check(0, "R10", "unexpected store", aa, 0);
        end else begin
          e = q_a.pop_front();
          a_seen++;
          check(aa == e.a && da == e.d, e.tag, "store event", {aa, da}, {e.a, e.d});
        end
      end
      prev_stall = va && !rdy_a;
      p_a = aa;
      p_d = da;

      if (vb) begin
        if (q_b.size() == 0) begin
          check(0, "R8", "unexpected store", ab, 0);
        end else begin
          e = q_b.pop_front();
          check(ab == e.a && db == e.d, e.tag, "store event", {ab, db}, {e.a, e.d});
        end
      end
    end

    check(a_seen >= 15, "R10", "loop iterations seen", a_seen, 15);
    check(q_b.size() == 0, "R8", "all second-program stores seen", q_b.size(), 0);

    for (int w = 0; w < 5 && sb != 3'd0; w++) @(negedge clk);
    check(pb == 8'd22, "R5", "branch self-loop pc", pb, 22);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule